// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Port

This block is a byte-wide serial peripheral interface port that sits on a simple processor register bus. Software configures it through a control register, watches a status register, and moves bytes through a data register. The port works as a bus master, where it generates the serial clock from the system clock with one of four divide ratios. It also works as a slave, where it follows a serial clock and a select line driven from outside. Both clock polarities and both clock phases are supported, and the bit order can be most-significant-first or least-significant-first.

A completed byte raises a done flag. A data write made while a byte is moving raises a collision flag and is otherwise ignored. Software clears a flag by reading the status register while the flag is set and then reading or writing the data register. An interrupt line is asserted while the done flag is set, provided both the local interrupt enable bit and an external serial-interrupt enable input are high. Every pin driver is given as a value plus an output-enable, and all enables are 0 while the port is switched off.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 8'h04, the status register reads 8'h00, sckOe, mosiOe, misoOe and irq are all 0.
- R2: Bus address 0 is the control register, with irqEn at bit 7, portOn at bit 6, lsbFirst at bit 5, masterSel at bit 4, cpol at bit 3, cpha at bit 2 and rate at bits 1:0. Address 1 is the status register, with the done flag at bit 7, the collision flag at bit 6 and bits 5:0 reading 0. Address 2 is the data register.
- R3: With portOn=1 and masterSel=1, sckOe and mosiOe are 1, misoOe is 0, and a data write while idle starts one 8-bit transfer. While no transfer runs, sckOut equals cpol.
- R4: In master mode, each half period of sckOut lasts 2, 8, 32 or 64 system clocks for rate 00, 01, 10 or 11 respectively. These are divide ratios of 4, 16, 64 and 128.
- R5: With cpha=0, each data bit is on the line before the leading serial-clock edge and is sampled on that edge. With cpha=1, the line changes on the leading edge and is sampled on the trailing edge.
- R6: With lsbFirst=0, bit 7 of the byte goes out first. With lsbFirst=1, bit 0 goes out first. The received byte is assembled in the same order.
- R7: When the eighth bit has been sampled, the done flag sets and a read of address 2 returns the received byte.
- R8: A data write while a transfer is in progress sets the collision flag. It leaves the outgoing and the received byte unchanged.
- R9: A flag clears only when a status read has seen it set and a later read or write of address 2 follows. A data access with no prior status read leaves the flags set.
- R10: irq is 1 exactly when the done flag, irqEn and the serialIrqEn input are all 1.
- R11: With portOn=0, all output enables are 0, and a data write starts no transfer and sets no flag.
- R12: With portOn=1 and masterSel=0, the port shifts only while ssN is low, misoOe follows ssN low, the transfer is clocked by sckIn, and the rate bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (drives clearing side effects) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register |
| serialIrqEn | input | 1 | External serial-interrupt enable |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock from the pin (slave mode) |
| sckOut | output | 1 | Serial clock to the pin (master mode) |
| sckOe | output | 1 | Serial clock driver enable |
| mosiIn | input | 1 | Master-out line from the pin (slave mode) |
| mosiOut | output | 1 | Master-out line value |
| mosiOe | output | 1 | Master-out driver enable |
| misoIn | input | 1 | Master-in line from the pin (master mode) |
| misoOut | output | 1 | Master-in line value (slave mode) |
| misoOe | output | 1 | Master-in driver enable |
| ssN | input | 1 | Active-low slave select |

## Verification
On every cycle, the assertions check four things. The enables must be off while the port is disabled. The interrupt must be gated by both enables and the done flag. A busy data write must be followed by the collision flag. The master clock must rest at its polarity when idle. In addition, the done flag may rise only out of a running transfer, and misoOe must drop once ssN has been high long enough to pass the synchronizer. The remaining behaviours need the bench's scenarios to show them: the exact bit order and phase on the line, the divider half-period for each rate, the received byte, the status-then-data clearing sequence, and slave transfers clocked from outside.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int EDGE_W = $clog2(2 * BYTE_W);
  localparam int DIV_W  = 6;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // strobes from control to the shift datapath
  typedef struct packed {
    logic load;     // take a new outgoing byte
    logic capture;  // leading edge: latch input bit, refresh delayed output bit
    logic shift;    // trailing edge: move one bit through the register
    logic finish;   // last trailing edge: publish received byte
  } engStrobe_t;

  // last count of the half-period divider for each rate code
  function automatic logic [DIV_W-1:0] halfLimit(input logic [1:0] rate);
    case (rate)
      2'b00:   halfLimit = DIV_W'(1);
      2'b01:   halfLimit = DIV_W'(7);
      2'b10:   halfLimit = DIV_W'(31);
      default: halfLimit = DIV_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  engStrobe_t        stb,
  input  logic              lsbFirst,
  input  logic              cpha,
  input  logic              inBit,
  input  logic [BYTE_W-1:0] loadData,
  output logic              lineOut,
  output logic [BYTE_W-1:0] rxData
);
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] shNext;
  logic              heldBit;
  logic              delayedOut;
  logic              outBit;
  logic              inSel;

  assign outBit  = lsbFirst ? shReg[0] : shReg[BYTE_W-1];
  assign inSel   = cpha ? inBit : heldBit;
  assign shNext  = lsbFirst ? {inSel, shReg[BYTE_W-1:1]} : {shReg[BYTE_W-2:0], inSel};
  assign lineOut = cpha ? delayedOut : outBit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg      <= '0;
      heldBit    <= 1'b0;
      delayedOut <= 1'b0;
      rxData     <= '0;
    end else begin
      if (stb.load) begin
        shReg <= loadData;
      end else if (stb.shift) begin
        shReg <= shNext;
      end
      if (stb.capture) begin
        heldBit    <= inBit;
        delayedOut <= outBit;
      end
      if (stb.finish) begin
        rxData <= shNext;
      end
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              serialIrqEn,
  output logic              irq,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  input  logic              ssN,
  output logic [7:0]        ctrlReg,
  output logic              inBit,
  output engStrobe_t        stb,
  output logic              busy,
  output logic              doneFlag,
  output logic              collFlag,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe
);
  logic irqEn, portOn, lsbUnused, isMaster, cpol;
  logic [1:0] rate;
  assign irqEn     = ctrlReg[7];
  assign portOn    = ctrlReg[6];
  assign lsbUnused = ctrlReg[5];
  assign isMaster  = ctrlReg[4];
  assign cpol      = ctrlReg[3];
  assign rate      = ctrlReg[1:0];

  // input synchronizers for slave-side pins
  logic [SYNC_N-1:0] sckSy, ssSy, mosiSy;
  logic sckS, ssS, prevSck;
  assign sckS = sckSy[SYNC_N-1];
  assign ssS  = ssSy[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSy   <= '0;
      ssSy    <= '1;
      mosiSy  <= '0;
      prevSck <= 1'b0;
    end else begin
      sckSy   <= {sckSy[SYNC_N-2:0], sckIn};
      ssSy    <= {ssSy[SYNC_N-2:0], ssN};
      mosiSy  <= {mosiSy[SYNC_N-2:0], mosiIn};
      prevSck <= sckS;
    end
  end

  logic masterActive, slaveActive;
  assign masterActive = portOn & isMaster;
  assign slaveActive  = portOn & ~isMaster & ~ssS;
  assign inBit        = isMaster ? misoIn : mosiSy[SYNC_N-1];

  logic dataWr, dataRd, statRd, ctrlWr, dataAcc;
  assign dataWr  = busWr & (busAddr == ADDR_DATA);
  assign dataRd  = busRd & (busAddr == ADDR_DATA);
  assign statRd  = busRd & (busAddr == ADDR_STAT);
  assign ctrlWr  = busWr & (busAddr == ADDR_CTRL);
  assign dataAcc = dataWr | dataRd;

  // edge engine
  logic              runM, sckLvl;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic              mEdge, sEdge, edgeNow, startM, lastEdge;

  assign busy     = runM | (edgeIdx != '0);
  assign startM   = dataWr & ~busy & masterActive;
  assign mEdge    = runM & (divCnt == halfLimit(rate));
  assign sEdge    = slaveActive & (sckS != prevSck);
  assign edgeNow  = mEdge | sEdge;
  assign lastEdge = &edgeIdx;

  always_comb begin
    stb.load    = dataWr & ~busy;
    stb.capture = edgeNow & ~edgeIdx[0];
    stb.shift   = edgeNow & edgeIdx[0];
    stb.finish  = edgeNow & lastEdge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runM    <= 1'b0;
      sckLvl  <= 1'b0;
      divCnt  <= '0;
      edgeIdx <= '0;
    end else if (!portOn) begin
      runM    <= 1'b0;
      sckLvl  <= 1'b0;
      divCnt  <= '0;
      edgeIdx <= '0;
    end else if (startM) begin
      runM    <= 1'b1;
      sckLvl  <= 1'b0;
      divCnt  <= '0;
      edgeIdx <= '0;
    end else if (runM) begin
      if (mEdge) begin
        divCnt  <= '0;
        sckLvl  <= ~sckLvl;
        edgeIdx <= edgeIdx + EDGE_W'(1);
        if (lastEdge) runM <= 1'b0;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end else if (!isMaster) begin
      if (ssS)        edgeIdx <= '0;
      else if (sEdge) edgeIdx <= edgeIdx + EDGE_W'(1);
    end
  end

  assign sckOut = cpol ^ sckLvl;
  assign sckOe  = masterActive;
  assign mosiOe = masterActive;
  assign misoOe = slaveActive;

  // registers and flags
  logic doneArm, collArm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg  <= 8'h04;
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      doneArm  <= 1'b0;
      collArm  <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= busWdata;
      doneFlag <= stb.finish | (doneFlag & ~(dataAcc & doneArm));
      collFlag <= (dataWr & busy) | (collFlag & ~(dataAcc & collArm));
      if (statRd) begin
        doneArm <= doneFlag;
        collArm <= collFlag;
      end else if (dataAcc) begin
        doneArm <= 1'b0;
        collArm <= 1'b0;
      end
    end
  end

  assign irq = doneFlag & irqEn & serialIrqEn;

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = ctrlReg;
      ADDR_STAT: busRdata = {doneFlag, collFlag, 6'b0};
      ADDR_DATA: busRdata = rxData;
      default:   busRdata = '0;
    endcase
  end

  logic unusedBits;
  assign unusedBits = lsbUnused;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              serialIrqEn,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  logic [7:0]        ctrlReg;
  logic [BYTE_W-1:0] rxData;
  logic              inBit, busy, doneFlag, collFlag, lineOut;
  engStrobe_t        stb;

  spi_port_ctrl #(.SYNC_N(SYNC_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxData(rxData),
    .serialIrqEn(serialIrqEn), .irq(irq), .sckIn(sckIn), .mosiIn(mosiIn),
    .misoIn(misoIn), .ssN(ssN), .ctrlReg(ctrlReg), .inBit(inBit), .stb(stb),
    .busy(busy), .doneFlag(doneFlag), .collFlag(collFlag), .sckOut(sckOut),
    .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe)
  );

  spi_port_dp u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .lsbFirst(ctrlReg[5]), .cpha(ctrlReg[2]),
    .inBit(inBit), .loadData(busWdata), .lineOut(lineOut), .rxData(rxData)
  );

  assign mosiOut = lineOut;
  assign misoOut = lineOut;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrlReg,
  input logic       busy,
  input logic       doneFlag,
  input logic       collFlag,
  input logic       irq,
  input logic       serialIrqEn,
  input logic       sckOut,
  input logic       sckOe,
  input logic       mosiOe,
  input logic       misoOe,
  input logic       ssN,
  input logic [1:0] busAddr,
  input logic       busWr
);
  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlReg[6] |-> (!sckOe && !mosiOe && !misoOe));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (serialIrqEn && ctrlReg[7] && doneFlag));

  assert_busy_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr == 2'd2 && busy) |=> collFlag);

  assert_idle_clock_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlReg[6] && ctrlReg[4] && !busy) |-> (sckOut == ctrlReg[3]));

  assert_done_from_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(busy));

  assert_deselect_releases_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlReg[4] && ssN && $past(ssN) && $past(ssN, 2)) |-> !misoOe);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrlReg(ctrlReg), .busy(busy), .doneFlag(doneFlag),
  .collFlag(collFlag), .irq(irq), .serialIrqEn(serialIrqEn), .sckOut(sckOut),
  .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe), .ssN(ssN),
  .busAddr(busAddr), .busWr(busWr)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, busWr, busRd, serialIrqEn, sckIn, mosiIn, ssN;
  logic [1:0] busAddr;
  logic [7:0] busWdata, busRdata;
  logic       irq, sckOut, sckOe, mosiOut, mosiOe, misoIn, misoOut, misoOe;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .serialIrqEn(serialIrqEn), .irq(irq),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut),
    .mosiOe(mosiOe), .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  assign misoIn = mosiOut;  // loopback for master transfers

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] expQ[$];
  logic tbCpol = 0, tbCpha = 0, tbLsb = 0, monOn = 0;
  int lastHalf = 0;

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  function automatic int halfOf(input logic [1:0] r);
    case (r)
      2'b00: return 2;
      2'b01: return 8;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  // monitor: rebuild each master byte from the line and compare with the queue
  initial begin
    logic prevSck = 1'b0;
    int sinceTog = 0;
    int nb = 0;
    logic [7:0] acc = '0;
    forever begin
      @(negedge clk);
      if (monOn && sckOut != prevSck) begin
        logic leading;
        lastHalf = sinceTog;
        sinceTog = 1;
        leading = (sckOut != tbCpol);
        if (tbCpha ? !leading : leading) begin
          if (tbLsb) acc[nb] = mosiOut; else acc[7-nb] = mosiOut;
          nb++;
          if (nb == 8) begin
            nb = 0;
            if (expQ.size() == 0) check("R6 unexpected byte on line", acc, 'h1FF);
            else check("R5/R6 master line byte", acc, expQ.pop_front());
          end
        end
      end else begin
        sinceTog++;
      end
      prevSck = sckOut;
    end
  end

  task automatic masterXfer(input logic pol, input logic pha, input logic lsb,
                            input logic [1:0] rate, input logic [7:0] tx,
                            input bit collide, input bit irqOn);
    int half;
    half = halfOf(rate);
    tbCpol = pol; tbCpha = pha; tbLsb = lsb;
    wrReg(2'd0, {irqOn, 1'b1, lsb, 1'b1, pol, pha, rate});
    repeat (2) @(negedge clk);
    check("R3 idle sck level", sckOut, pol);
    check("R3 master enables", {sckOe, mosiOe, misoOe}, 3'b110);
    monOn = 1'b1;
    expQ.push_back(tx);
    wrReg(2'd2, tx);
    if (collide) begin
      repeat (3) @(negedge clk);
      wrReg(2'd2, ~tx);
    end
    repeat (16 * half + 12) @(negedge clk);
    monOn = 1'b0;
    check("R5 all expected bytes seen", expQ.size(), 0);
    check("R4 sck half period", lastHalf, half);
    check("R3 sck back at idle", sckOut, pol);
  endtask

  task automatic slaveXfer(input logic pol, input logic pha, input logic lsb,
                           input logic [7:0] txSlave, input logic [7:0] fromMaster);
    logic [7:0] got;
    logic [7:0] d;
    got = '0;
    sckIn = pol; ssN = 1'b1;
    repeat (4) @(negedge clk);
    wrReg(2'd0, {1'b0, 1'b1, lsb, 1'b0, pol, pha, 2'b11});
    repeat (4) @(negedge clk);
    check("R12 miso released while deselected", misoOe, 0);
    check("R12 slave drives no clock or mosi", {sckOe, mosiOe}, 2'b00);
    wrReg(2'd2, txSlave);
    expQ.push_back(txSlave);
    ssN = 1'b0;
    repeat (8) @(negedge clk);
    check("R12 miso driven while selected", misoOe, 1);
    for (int i = 0; i < 8; i++) begin
      int b;
      b = lsb ? i : 7 - i;
      if (!pha) begin
        mosiIn = fromMaster[b];
        repeat (8) @(negedge clk);
        got[b] = misoOut;
        sckIn = ~pol;
        repeat (8) @(negedge clk);
        sckIn = pol;
      end else begin
        sckIn = ~pol;
        mosiIn = fromMaster[b];
        repeat (8) @(negedge clk);
        got[b] = misoOut;
        sckIn = pol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ssN = 1'b1;
    check("R12 slave miso byte", got, expQ.pop_front());
    rdReg(2'd1, d);
    check("R7 slave done flag", d, 8'h80);
    rdReg(2'd2, d);
    check("R12 slave received byte", d, fromMaster);
    rdReg(2'd1, d);
    check("R9 slave flags cleared", d, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog R1 run did not finish actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; busWr = 0; busRd = 0; busAddr = 0; busWdata = 0;
    serialIrqEn = 0; sckIn = 0; mosiIn = 0; ssN = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rdReg(2'd0, d); check("R1 control reset value", d, 8'h04);
    rdReg(2'd1, d); check("R1 status reset value", d, 8'h00);
    check("R1 enables and irq after reset", {sckOe, mosiOe, misoOe, irq}, 4'b0000);

    // mode 0, msb first, fastest rate
    masterXfer(1'b0, 1'b0, 1'b0, 2'b00, 8'hA5, 0, 0);
    rdReg(2'd2, d); check("R7 received byte", d, 8'hA5);
    rdReg(2'd1, d); check("R9 flag kept without prior status read", d, 8'h80);
    rdReg(2'd2, d);
    rdReg(2'd1, d); check("R9 flag cleared by status then data", d, 8'h00);

    // mode 3, lsb first, rate 01, interrupt gating
    masterXfer(1'b1, 1'b1, 1'b1, 2'b01, 8'h3C, 0, 1);
    check("R10 irq blocked by serialIrqEn", irq, 0);
    @(negedge clk); serialIrqEn = 1'b1;
    @(negedge clk); check("R10 irq raised", irq, 1);
    rdReg(2'd1, d); check("R2 status layout done", d, 8'h80);
    rdReg(2'd2, d); check("R7 received byte lsb first", d, 8'h3C);
    @(negedge clk); check("R10 irq drops with flag", irq, 0);
    serialIrqEn = 1'b0;

    // mode 1, msb first, rate 10, collision
    masterXfer(1'b0, 1'b1, 1'b0, 2'b10, 8'h96, 1, 0);
    rdReg(2'd1, d); check("R8 collision and done flags", d, 8'hC0);
    rdReg(2'd2, d); check("R8 received byte not corrupted", d, 8'h96);
    rdReg(2'd1, d); check("R9 both flags cleared", d, 8'h00);

    // mode 2, lsb first, slowest rate
    masterXfer(1'b1, 1'b0, 1'b1, 2'b11, 8'h01, 0, 0);
    rdReg(2'd1, d); check("R7 done at rate 11", d, 8'h80);
    rdReg(2'd2, d); check("R6 lsb-first byte", d, 8'h01);

    // disabled port
    wrReg(2'd0, 8'h1C);
    wrReg(2'd2, 8'h55);
    repeat (200) @(negedge clk);
    check("R11 enables off when disabled", {sckOe, mosiOe, misoOe}, 3'b000);
    rdReg(2'd1, d); check("R11 no transfer when disabled", d, 8'h00);

    // slave transfers
    slaveXfer(1'b0, 1'b0, 1'b0, 8'hC3, 8'h5A);
    slaveXfer(1'b1, 1'b1, 1'b1, 8'h81, 8'hE7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule